// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Completion

The block gathers level-driven interrupt requests from a set of sources and presents one interrupt line per target context. Each source has a pending bit, a claimed bit and a small priority value. Each context has its own enable bitmap and a priority threshold. A context's line is raised while some source is pending, not claimed, enabled for it, and above its threshold.

Software running on a target reads that context's claim register. The read returns the lowest-numbered eligible source and, in the same cycle, moves the source from pending to claimed, so the source stops counting toward any context. When service is finished, software writes the source number back to the same register. That completion releases the claimed bit. All configuration and status is reached through a simple 32-bit word bus. Reads return data one cycle after the access. Accesses that fall outside the map are flagged with a one-cycle error pulse.

Top module: `plat_irq_ctrl`

## Requirements
- R1: A source's pending bit is set on the cycle its input goes from low to high and cleared on the cycle it goes from high to low. A claim clears it, and it stays clear until the input changes again. Pending words are read at 0x1000 + 4·w, with bit j of word w holding source 32·w + j.
- R2: A source is eligible for a context only when all four of these hold: it is pending, it is not claimed, it is enabled for that context, and its priority is strictly greater than that context's threshold.
- R3: Output irq_out[c] is high exactly when at least one source is eligible for context c. It reflects the state registered at the most recent clock edge.
- R4: A read of context c's claim register (0x4004 + 0x1000·c) returns the lowest-numbered source eligible for c, whatever the priorities. In the same cycle that source's pending bit is cleared and its claimed bit is set.
- R5: A claim read with no eligible source returns 0 and changes no pending or claimed bit.
- R6: A write of value v to a claim register clears the claimed bit of source v when v is below the number of sources. Larger values change nothing.
- R7: The priority of source i is at 0x0000 + 4·i. A write stores bits [2:0] of the data, and a read returns the stored value.
- R8: The threshold of context c is at 0x4000 + 0x1000·c. A write takes effect only when the data value is at most 7, and a read returns the stored threshold.
- R9: The enable word w of context c is at 0x2000 + 0x80·c + 4·w. Bit j controls source 32·w + j, and each context's bitmap is independent of the others.
- R10: A write to the pending region raises the error flag and leaves every pending bit unchanged.
- R11: An access whose address is not a multiple of 4 is an error, and so is one that hits no register. Such accesses include a priority beyond the last source, an enable word beyond the last one, and a context offset other than 0 or 4. An erroring read returns 0, and an erroring write changes nothing.
- R12: After reset every pending, claimed, enable and priority bit is 0, every threshold is 0, and every interrupt line is low.
- R13: Read data and the error flag appear in the cycle after the access, and the error flag is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | NUM_SRC | Level of each interrupt source |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | One-cycle error flag for the previous access |
| irq_out | output | NUM_CTX | Interrupt line per context |

## Verification
A pending or claimed bit held in the wrong state shows up as a wrong interrupt line in the next cycle. It also shows up as a wrong source number on the next claim read, so the bench checks the lines after each input change and each register write, as well as the claim results. A lost completion keeps a source masked indefinitely. A claim that fails to move a source to claimed lets it be granted twice. The sequences therefore complete and re-raise sources, then claim again, and the results are checked a cycle later. A decode error appears at once as a stray error pulse or as nonzero data from a hole in the map. A write that lands at the wrong place only shows when the affected register is read back.

// File: rtl/plat_irq_pkg.sv
package plat_irq_pkg;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_PRIO  = 3'd1,
    RG_PEND  = 3'd2,
    RG_EN    = 3'd3,
    RG_THR   = 3'd4,
    RG_CLAIM = 3'd5
  } region_e;

  // number of 32-bit words needed for one bit per source
  function automatic int unsigned word_count(input int unsigned n);
    return (n + 31) / 32;
  endfunction

  // half-open address window test
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                     input logic [31:0] len);
    return (a >= base) && (a < base + len);
  endfunction

  // threshold write acceptance
  function automatic logic thr_ok(input logic [31:0] v, input int unsigned max_prio);
    return v <= max_prio;
  endfunction

endpackage

// File: rtl/plat_irq_decode.sv
module plat_irq_decode
  import plat_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned CTX_W      = 1,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h0080,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [CTX_W-1:0]  ctx,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned NWORDS = word_count(NUM_SRC);
  localparam int unsigned EN_SH  = $clog2(EN_STRIDE);
  localparam int unsigned CX_SH  = $clog2(CTX_STRIDE);

  logic [31:0] a;
  logic [31:0] rel_en;
  logic [31:0] rel_cx;
  logic [31:0] en_off;
  logic [31:0] cx_off;

  assign a      = 32'(addr);
  assign rel_en = a - EN_BASE;
  assign rel_cx = a - CTX_BASE;
  assign en_off = rel_en & (EN_STRIDE - 1);
  assign cx_off = rel_cx & (CTX_STRIDE - 1);

  always_comb begin
    region = RG_NONE;
    ctx    = '0;
    idx    = '0;
    if (a[1:0] == 2'b00) begin
      if (in_window(a, PRIO_BASE, 4 * NUM_SRC)) begin
        region = RG_PRIO;
        idx    = IDX_W'((a - PRIO_BASE) >> 2);
      end else if (in_window(a, PEND_BASE, 4 * NWORDS)) begin
        region = RG_PEND;
        idx    = IDX_W'((a - PEND_BASE) >> 2);
      end else if (in_window(a, EN_BASE, NUM_CTX * EN_STRIDE)) begin
        if ((en_off >> 2) < NWORDS) begin
          region = RG_EN;
          ctx    = CTX_W'(rel_en >> EN_SH);
          idx    = IDX_W'(en_off >> 2);
        end
      end else if (in_window(a, CTX_BASE, NUM_CTX * CTX_STRIDE)) begin
        ctx = CTX_W'(rel_cx >> CX_SH);
        if (cx_off == 32'd0)      region = RG_THR;
        else if (cx_off == 32'd4) region = RG_CLAIM;
      end
    end
  end

endmodule

// File: rtl/plat_irq_src_bank.sv
module plat_irq_src_bank #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_level,
  input  logic [NUM_SRC-1:0]              claim_take,
  input  logic [NUM_SRC-1:0]              done_clr,
  input  logic                            prio_we,
  input  logic [IDX_W-1:0]                prio_idx,
  input  logic [PRIO_W-1:0]               prio_wdata,
  output logic [NUM_SRC-1:0]              pending,
  output logic [NUM_SRC-1:0]              claimed,
  output logic [NUM_SRC-1:0]              src_rise,
  output logic [NUM_SRC-1:0]              src_fall,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio
);

  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] pend_n;
  logic [NUM_SRC-1:0] clm_n;

  assign src_rise = src_level & ~lvl_q;
  assign src_fall = ~src_level & lvl_q;

  // claim is applied first, then input edges and completions
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      pend_n[s] = pending[s];
      if (claim_take[s]) pend_n[s] = 1'b0;
      if (src_rise[s])      pend_n[s] = 1'b1;
      else if (src_fall[s]) pend_n[s] = 1'b0;
      clm_n[s] = claimed[s];
      if (claim_take[s]) clm_n[s] = 1'b1;
      if (done_clr[s])   clm_n[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      pending <= '0;
      claimed <= '0;
      prio    <= '0;
    end else begin
      lvl_q   <= src_level;
      pending <= pend_n;
      claimed <= clm_n;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (prio_we && (prio_idx == IDX_W'(s))) prio[s] <= prio_wdata;
      end
    end
  end

endmodule

// File: rtl/plat_irq_pick.sv
module plat_irq_pick #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0]             pending,
  input  logic [NUM_SRC-1:0]             claimed,
  input  logic [NUM_SRC-1:0]             enable,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              thr,
  output logic                           any,
  output logic [IDX_W-1:0]               win_idx,
  output logic [NUM_SRC-1:0]             win_hot
);

  logic [NUM_SRC-1:0] above;
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) above[s] = prio[s] > thr;
  end

  assign elig    = pending & ~claimed & enable & above;
  assign any     = |elig;
  // isolate the lowest set bit
  assign win_hot = elig & (~elig + NUM_SRC'(1));

  always_comb begin
    win_idx = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig[s]) win_idx = IDX_W'(s);
    end
  end

endmodule

// File: rtl/plat_irq_ctrl.sv
module plat_irq_ctrl
  import plat_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h0080,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  output logic [NUM_CTX-1:0] irq_out
);

  localparam int unsigned CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned MAX_PRIO = (1 << PRIO_W) - 1;

  // decode
  region_e          dec_region;
  logic [CTX_W-1:0] dec_ctx;
  logic [IDX_W-1:0] dec_idx;

  plat_irq_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .CTX_W(CTX_W), .IDX_W(IDX_W),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
    .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(bus_addr), .region(dec_region), .ctx(dec_ctx), .idx(dec_idx)
  );

  // named access events
  logic rd_fire, wr_fire;
  logic claim_fire, cpl_fire, prio_we, en_we, thr_we, thr_accept, acc_err;

  assign rd_fire    = bus_valid && !bus_write;
  assign wr_fire    = bus_valid &&  bus_write;
  assign claim_fire = rd_fire && (dec_region == RG_CLAIM);
  assign cpl_fire   = wr_fire && (dec_region == RG_CLAIM);
  assign prio_we    = wr_fire && (dec_region == RG_PRIO);
  assign en_we      = wr_fire && (dec_region == RG_EN);
  assign thr_we     = wr_fire && (dec_region == RG_THR);
  assign thr_accept = thr_we && thr_ok(bus_wdata, MAX_PRIO);
  assign acc_err    = bus_valid &&
                      ((dec_region == RG_NONE) || (bus_write && (dec_region == RG_PEND)));

  // per-context configuration
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (en_we) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if ((s / 32) == int'(dec_idx)) en_q[dec_ctx][s] <= bus_wdata[s % 32];
        end
      end
      if (thr_accept) thr_q[dec_ctx] <= bus_wdata[PRIO_W-1:0];
    end
  end

  // source state
  logic [NUM_SRC-1:0]             pending, claimed, src_rise, src_fall;
  logic [NUM_SRC-1:0]             claim_take, done_clr;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

  plat_irq_src_bank #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .claim_take(claim_take), .done_clr(done_clr),
    .prio_we(prio_we), .prio_idx(dec_idx), .prio_wdata(bus_wdata[PRIO_W-1:0]),
    .pending(pending), .claimed(claimed),
    .src_rise(src_rise), .src_fall(src_fall), .prio(prio_q)
  );

  // one selector per context
  logic [NUM_CTX-1:0]              ctx_any;
  logic [NUM_CTX-1:0][IDX_W-1:0]   ctx_win;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] ctx_hot;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    plat_irq_pick #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_pick (
      .pending(pending), .claimed(claimed), .enable(en_q[c]),
      .prio(prio_q), .thr(thr_q[c]),
      .any(ctx_any[c]), .win_idx(ctx_win[c]), .win_hot(ctx_hot[c])
    );
  end

  assign irq_out = ctx_any;

  // claim and completion
  logic             claim_any;
  logic [IDX_W-1:0] claim_id;

  assign claim_any  = ctx_any[dec_ctx];
  assign claim_id   = ctx_win[dec_ctx];
  assign claim_take = claim_fire ? ctx_hot[dec_ctx] : '0;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) done_clr[s] = cpl_fire && (bus_wdata == 32'(s));
  end

  // read mux and response register
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (dec_region)
      RG_PRIO: rd_next = 32'(prio_q[dec_idx]);
      RG_PEND: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if ((s / 32) == int'(dec_idx)) rd_next[s % 32] = pending[s];
        end
      end
      RG_EN: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if ((s / 32) == int'(dec_idx)) rd_next[s % 32] = en_q[dec_ctx][s];
        end
      end
      RG_THR:   rd_next = 32'(thr_q[dec_ctx]);
      RG_CLAIM: rd_next = claim_any ? 32'(claim_id) : 32'd0;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= acc_err;
      bus_rdata <= rd_fire ? rd_next : 32'd0;
    end
  end

endmodule

// File: rtl/plat_irq_ctrl_chk.sv
module plat_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_err,
  input logic [31:0]        bus_rdata,
  input logic [NUM_CTX-1:0] irq_out,
  input logic [NUM_SRC-1:0] pending,
  input logic [NUM_SRC-1:0] claimed,
  input logic [NUM_SRC-1:0] src_rise,
  input logic [NUM_SRC-1:0] src_fall,
  input logic               claim_fire,
  input logic               claim_any,
  input logic [NUM_SRC-1:0] claim_take,
  input logic               cpl_fire
);

  a_r1_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_rise) |=> ((pending & $past(src_rise)) == $past(src_rise)));

  a_r1_fall_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_fall) |=> ((pending & $past(src_fall)) == '0));

  a_r3_quiet_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~claimed) == '0) |-> (irq_out == '0));

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_take));

  a_r4_grant_marks_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_take) |=> ((claimed & $past(claim_take)) == $past(claim_take)));

  a_r4_grant_only_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_take) |-> (claim_fire && claim_any));

  a_r5_empty_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && !claim_any) |=> (bus_rdata == 32'd0));

  a_r6_completion_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire |=> ((claimed & ~$past(claimed)) == '0));

  a_r13_err_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid));

  a_r11_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'd0));

endmodule

bind plat_irq_ctrl plat_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_err(bus_err),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .pending(pending), .claimed(claimed),
  .src_rise(src_rise), .src_fall(src_fall), .claim_fire(claim_fire),
  .claim_any(claim_any), .claim_take(claim_take), .cpl_fire(cpl_fire)
);

// File: tb/plat_irq_ctrl_tb.sv
`timescale 1ns/1ps
module plat_irq_ctrl_tb;

  localparam int NS = 32;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  wire  [31:0]   bus_rdata;
  wire           bus_err;
  wire  [NC-1:0] irq_out;

  always #2.5 clk = ~clk;

  plat_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_level(src),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_out(irq_out)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    bit          chk_data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   acc_seen = 1'b0;
  bit   done = 1'b0;

  // R13: the response belongs to the access accepted at the previous edge
  always @(posedge clk) acc_seen <= bus_valid;

  always @(negedge clk) begin
    exp_t e;
    if (acc_seen) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R13 scoreboard: got rdata=%h err=%b, expected no response", bus_rdata, bus_err);
      end else begin
        e = sb.pop_front();
        if (bus_err !== e.err || (e.chk_data && bus_rdata !== e.data)) begin
          errors++;
          $display("FAIL %s: rdata=%h err=%b, expected rdata=%h err=%b",
                   e.tag, bus_rdata, bus_err, e.data, e.err);
        end
      end
    end
  end

  task automatic bus_rd(input logic [15:0] a, input logic [31:0] d, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    e.data = d; e.err = er; e.chk_data = 1'b1; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    e.data = '0; e.err = er; e.chk_data = 1'b0; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic check_irq(input logic [NC-1:0] exp, input string tag);
    checks++;
    if (irq_out !== exp) begin
      errors++;
      $display("FAIL %s: irq_out=%b, expected %b", tag, irq_out, exp);
    end
  endtask

  task automatic check_err_low(input string tag);
    @(negedge clk);
    checks++;
    if (bus_err !== 1'b0) begin
      errors++;
      $display("FAIL %s: bus_err=%b, expected 0", tag, bus_err);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check_irq(2'b00, "R12 lines low after reset");
    bus_rd(16'h0014, 32'h0, 1'b0, "R12 priority reset");
    bus_rd(16'h1000, 32'h0, 1'b0, "R12 pending reset");
    bus_rd(16'h2000, 32'h0, 1'b0, "R12 enable reset");
    bus_rd(16'h5000, 32'h0, 1'b0, "R12 threshold reset");

    // R7 priority storage
    bus_wr(16'h0014, 32'hFF, 1'b0, "R7 write prio5");
    bus_rd(16'h0014, 32'h7, 1'b0, "R7 prio5 keeps low bits");
    bus_wr(16'h000C, 32'h0A, 1'b0, "R7 write prio3");
    bus_rd(16'h000C, 32'h2, 1'b0, "R7 prio3 truncated");

    // R1 rising inputs
    set_src(3, 1'b1);
    set_src(5, 1'b1);
    set_src(9, 1'b1);
    bus_rd(16'h1000, 32'h228, 1'b0, "R1 pending after rises");
    check_irq(2'b00, "R2 nothing enabled");

    // R9 enables
    bus_wr(16'h2000, 32'h228, 1'b0, "R9 enable ctx0");
    bus_rd(16'h2000, 32'h228, 1'b0, "R9 enable ctx0 readback");
    bus_rd(16'h2080, 32'h0, 1'b0, "R9 ctx1 bitmap separate");
    check_irq(2'b01, "R3 ctx0 raised");

    // R8 threshold
    bus_wr(16'h4000, 32'd8, 1'b0, "R8 over-max write");
    bus_rd(16'h4000, 32'd0, 1'b0, "R8 over-max threshold ignored");
    bus_wr(16'h4000, 32'd7, 1'b0, "R8 write 7");
    bus_rd(16'h4000, 32'd7, 1'b0, "R8 threshold 7 stored");
    check_irq(2'b00, "R2 priority equal to threshold masked");
    bus_wr(16'h4000, 32'd2, 1'b0, "R8 write 2");
    check_irq(2'b01, "R2 prio5 above threshold 2");

    // R4 claim
    bus_rd(16'h4004, 32'd5, 1'b0, "R4 claim skips src3 at threshold");
    bus_rd(16'h1000, 32'h208, 1'b0, "R4 claim cleared pending5");
    check_irq(2'b00, "R3 ctx0 drops after claim");
    bus_wr(16'h4000, 32'd0, 1'b0, "R8 write 0");
    check_irq(2'b01, "R2 src3 eligible at threshold 0");
    bus_rd(16'h4004, 32'd3, 1'b0, "R4 claim src3");
    bus_rd(16'h1000, 32'h200, 1'b0, "R4 pending after second claim");

    // R5 empty claim
    bus_rd(16'h4004, 32'd0, 1'b0, "R5 empty claim returns 0");
    bus_rd(16'h1000, 32'h200, 1'b0, "R5 empty claim leaves pending");

    // R6 completion
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    check_irq(2'b00, "R2 claimed source masked");
    bus_wr(16'h4004, 32'd40, 1'b0, "R6 oversize completion");
    check_irq(2'b00, "R6 oversize completion ignored");
    bus_wr(16'h4004, 32'd5, 1'b0, "R6 complete src5");
    check_irq(2'b01, "R6 completion re-enables src5");
    bus_rd(16'h4004, 32'd5, 1'b0, "R4 reclaim src5");

    // R4 lowest index beats higher priority
    bus_wr(16'h0024, 32'd4, 1'b0, "R7 write prio9");
    bus_wr(16'h4004, 32'd3, 1'b0, "R6 complete src3");
    bus_wr(16'h4004, 32'd5, 1'b0, "R6 complete src5 again");
    set_src(3, 1'b0);
    set_src(3, 1'b1);
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    bus_rd(16'h1000, 32'h228, 1'b0, "R1 pending rebuilt by edges");
    bus_rd(16'h4004, 32'd3, 1'b0, "R4 lowest index wins over higher priority");

    // second context
    bus_wr(16'h2080, 32'h200, 1'b0, "R9 enable ctx1");
    check_irq(2'b11, "R9 ctx1 raised by bit9");
    bus_rd(16'h5004, 32'd9, 1'b0, "R4 ctx1 claims src9");
    check_irq(2'b01, "R3 ctx1 drops after claim");
    bus_wr(16'h5000, 32'd5, 1'b0, "R8 write ctx1 threshold");
    bus_rd(16'h5000, 32'd5, 1'b0, "R8 ctx1 threshold stored");
    bus_rd(16'h4000, 32'd0, 1'b0, "R8 ctx0 threshold untouched");

    // R10 pending is read-only
    bus_wr(16'h1000, 32'hFFFF_FFFF, 1'b1, "R10 pending write rejected");
    bus_rd(16'h1000, 32'h20, 1'b0, "R10 pending unchanged");

    // R11 errors, R13 pulse width
    bus_rd(16'h0002, 32'h0, 1'b1, "R11 misaligned read");
    check_err_low("R13 error flag lasts one cycle");
    bus_rd(16'h3000, 32'h0, 1'b1, "R11 unmapped read");
    bus_rd(16'h0080, 32'h0, 1'b1, "R11 priority past last source");
    bus_rd(16'h2004, 32'h0, 1'b1, "R11 enable word past end");
    bus_wr(16'h4008, 32'h0, 1'b1, "R11 context offset 8");
    bus_wr(16'h0015, 32'h0, 1'b1, "R11 misaligned write");
    bus_rd(16'h0014, 32'h7, 1'b0, "R11 prio5 untouched by bad write");

    // R1 falling input
    set_src(5, 1'b0);
    bus_rd(16'h1000, 32'h0, 1'b0, "R1 fall clears pending5");
    check_irq(2'b00, "R3 no eligible source left");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R13 scoreboard: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule